// File: doc/BRIEF.md
# Endian-Aware Bus-Width Matcher

This block sits between a fixed 36-bit datapath and a narrow port. The narrow port can be set to the full 36-bit width, an 18-bit half width or a 9-bit quarter width. In the outbound direction it accepts one 36-bit word and hands it out over the narrow port as one, two or four pieces. In the inbound direction it takes one, two or four narrow pieces and puts them back together into one 36-bit word. Every interface uses a valid/ready handshake.

The piece order follows an endian select. With big-endian order, the most significant piece of the 36-bit word travels first. With little-endian order, the least significant piece travels first.

The width select (bus-match and size pins) and the endian pin are captured only while the synchronous active-low reset is held. They are frozen after reset, so a new configuration needs another reset. The same reset also throws away any word that is only partly split or partly assembled.

Top module: `bus_width_matcher`

## Requirements
- R1: While reset is low and in the first cycle after it, `wide_in_ready` and `nar_in_ready` are 1 and `nar_out_valid` and `wide_out_valid` are 0.
- R2: In full width (bus_match=0), an accepted wide word is given out as exactly one narrow piece equal to the word, and that piece is valid in the cycle after acceptance.
- R3: In half width (bus_match=1, size_sel=0), the outbound pieces are bits [17:0] then [35:18] in little-endian order, and [35:18] then [17:0] in big-endian order.
- R4: In quarter width (bus_match=1, size_sel=1), the outbound pieces are the 9-bit lanes [8:0], [17:9], [26:18], [35:27] in that order for little-endian, and in the reverse order for big-endian.
- R5: `wide_in_ready` is 0 from the cycle after a wide word is accepted until the cycle after its last narrow piece is accepted, and it is 1 again in that cycle.
- R6: In full width, one narrow input piece becomes one wide output word equal to it.
- R7: In half width, the first of two inbound pieces fills bits [17:0] for little-endian or bits [35:18] for big-endian, and the second piece fills the other half.
- R8: In quarter width, the k-th inbound piece (k = 0..3) fills lane k for little-endian and lane 3-k for big-endian. Lane k is bits [9k+8:9k].
- R9: `wide_out_valid` rises only in the cycle after the last piece of a word is accepted. While the wide word is held, `nar_in_ready` is 0 and the word is stable.
- R10: bus_match, size_sel and big_endian are sampled only while rst_n is low. Changing them afterwards does not change piece count or order.
- R11: A reset while a word is partly assembled discards the collected pieces. The next word is built only from pieces received after reset.
- R12: Narrow input bits above the active piece width are ignored, and narrow output bits above the active piece width are 0.
- R13: While `nar_out_valid` is 1 and `nar_out_ready` is 0, the narrow output piece and its valid stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration is sampled while low |
| bus_match | input | 1 | 0 selects full width; 1 selects a narrow width through size_sel |
| size_sel | input | 1 | With bus_match=1: 0 selects 18-bit pieces, 1 selects 9-bit pieces |
| big_endian | input | 1 | 1 sends the most significant piece first, 0 the least significant |
| wide_in_valid | input | 1 | Outbound wide word is valid |
| wide_in_ready | output | 1 | Splitter can take a new wide word |
| wide_in_data | input | 36 | Outbound wide word |
| nar_out_valid | output | 1 | Narrow output piece is valid |
| nar_out_ready | input | 1 | Consumer takes the narrow piece |
| nar_out_data | output | 36 | Narrow piece, zero-extended |
| nar_in_valid | input | 1 | Inbound narrow piece is valid |
| nar_in_ready | output | 1 | Packer can take a narrow piece |
| nar_in_data | input | 36 | Inbound narrow piece in the low bits |
| wide_out_valid | output | 1 | Assembled wide word is valid |
| wide_out_ready | input | 1 | Consumer takes the wide word |
| wide_out_data | output | 36 | Assembled wide word |

## Verification
Each result has a fixed due cycle:
- The first narrow piece is due one cycle after its wide word is accepted.
- Each later piece is due one cycle after the previous piece's handshake.
- `wide_in_ready` comes back one cycle after the last piece's handshake.
- The assembled wide word appears one cycle after the last inbound piece is accepted.

The bench drives every input on the falling edge. It samples on the next falling edge, which lies one register stage after the rising edge that did the handshake. It checks the values expected for that exact cycle, including ready being low and valid being absent before the due cycle.

// File: rtl/bwm_pkg.sv
// Package: shared width-mode type and piece-index helpers for the
// bus-width matcher. Assumes the wide word splits into four equal lanes.
package bwm_pkg;

    localparam int unsigned LANE_CNT = 4;
    localparam int unsigned CNT_W    = $clog2(LANE_CNT);

    typedef enum logic [1:0] {
        WIDTH_FULL    = 2'd0,
        WIDTH_HALF    = 2'd1,
        WIDTH_QUARTER = 2'd2
    } width_e;

    // Map the two width pins onto a width mode.
    function automatic width_e decode_width(input logic bm, input logic sz);
        if (!bm)
            return WIDTH_FULL;
        else if (sz)
            return WIDTH_QUARTER;
        return WIDTH_HALF;
    endfunction

    // Index of the final piece of one wide word for a width mode.
    function automatic logic [CNT_W-1:0] last_piece(input width_e w);
        case (w)
            WIDTH_FULL: return CNT_W'(0);
            WIDTH_HALF: return CNT_W'(1);
            default:    return CNT_W'(LANE_CNT - 1);
        endcase
    endfunction

    // Slot of the wide word that the k-th transferred piece occupies.
    function automatic logic [CNT_W-1:0] piece_slot(input width_e w,
                                                    input logic big,
                                                    input logic [CNT_W-1:0] k);
        return big ? (last_piece(w) - k) : k;
    endfunction

endpackage

// File: rtl/bwm_cfg.sv
// Configuration latch: samples the width pins and endian pin while the
// synchronous active-low reset is held, then keeps them frozen.
// Assumes the pins are settled for at least one clock inside reset.
module bwm_cfg
    import bwm_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   bus_match_i,
    input  logic   size_sel_i,
    input  logic   big_endian_i,
    output width_e width_o,
    output logic   big_o
);

    width_e width_q;
    logic   big_q;

    // Capture configuration during reset, hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            width_q <= decode_width(bus_match_i, size_sel_i);
            big_q   <= big_endian_i;
        end
    end

    assign width_o = width_q;
    assign big_o   = big_q;

endmodule

// File: rtl/bwm_slice.sv
// Piece selector: picks one slot of a wide word for the active width mode
// and zero-extends it to the full width. Purely combinational.
// Assumes WORD_W is a multiple of four.
module bwm_slice
    import bwm_pkg::*;
#(
    parameter int unsigned WORD_W = 36
) (
    input  logic [WORD_W-1:0] word_i,
    input  width_e            width_i,
    input  logic [CNT_W-1:0]  slot_i,
    output logic [WORD_W-1:0] piece_o
);

    localparam int unsigned LANE_W = WORD_W / LANE_CNT;
    localparam int unsigned HALF_W = WORD_W / 2;

    logic [LANE_W-1:0] lane [LANE_CNT];
    logic [HALF_W-1:0] half [2];

    genvar g;
    generate
        for (g = 0; g < LANE_CNT; g++) begin : g_lane
            assign lane[g] = word_i[g*LANE_W +: LANE_W];
        end
        for (g = 0; g < 2; g++) begin : g_half
            assign half[g] = word_i[g*HALF_W +: HALF_W];
        end
    endgenerate

    // Route the selected slot to the low bits of the piece output.
    always_comb begin
        case (width_i)
            WIDTH_FULL: piece_o = word_i;
            WIDTH_HALF: piece_o = WORD_W'(half[slot_i[0]]);
            default:    piece_o = WORD_W'(lane[slot_i]);
        endcase
    end

endmodule

// File: rtl/bwm_splitter.sv
// Wide-to-narrow splitter: registers one wide word, then presents it as one,
// two or four narrow pieces in endian order. It takes a new word only once
// the final piece has been handed over.
module bwm_splitter
    import bwm_pkg::*;
#(
    parameter int unsigned WORD_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  width_e            width_i,
    input  logic              big_i,
    input  logic              in_valid_i,
    output logic              in_ready_o,
    input  logic [WORD_W-1:0] in_data_i,
    output logic              out_valid_o,
    input  logic              out_ready_i,
    output logic [WORD_W-1:0] out_data_o
);

    logic [WORD_W-1:0] hold_q;
    logic              busy_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              take;
    logic              give;
    logic [CNT_W-1:0]  slot;

    assign take        = in_valid_i && !busy_q;
    assign give        = busy_q && out_ready_i;
    assign in_ready_o  = !busy_q;
    assign out_valid_o = busy_q;
    assign slot        = piece_slot(width_i, big_i, cnt_q);

    // Load a word when idle; advance the piece count on each handover.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (take) begin
            hold_q <= in_data_i;
            busy_q <= 1'b1;
            cnt_q  <= '0;
        end else if (give) begin
            if (cnt_q == last_piece(width_i)) begin
                busy_q <= 1'b0;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    bwm_slice #(.WORD_W(WORD_W)) u_slice (
        .word_i  (hold_q),
        .width_i (width_i),
        .slot_i  (slot),
        .piece_o (out_data_o)
    );

endmodule

// File: rtl/bwm_packer.sv
// Narrow-to-wide packer: writes each narrow piece into its endian slot of
// an accumulator and presents the wide word once all pieces are in.
// Input bits above the active piece width are ignored.
module bwm_packer
    import bwm_pkg::*;
#(
    parameter int unsigned WORD_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  width_e            width_i,
    input  logic              big_i,
    input  logic              in_valid_i,
    output logic              in_ready_o,
    input  logic [WORD_W-1:0] in_data_i,
    output logic              out_valid_o,
    input  logic              out_ready_i,
    output logic [WORD_W-1:0] out_data_o
);

    localparam int unsigned LANE_W = WORD_W / LANE_CNT;
    localparam int unsigned HALF_W = WORD_W / 2;

    logic [WORD_W-1:0] acc_q;
    logic              full_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              take;
    logic [CNT_W-1:0]  slot;

    assign take        = in_valid_i && !full_q;
    assign in_ready_o  = !full_q;
    assign out_valid_o = full_q;
    assign out_data_o  = acc_q;
    assign slot        = piece_slot(width_i, big_i, cnt_q);

    // Write the incoming piece into its slot of the accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (take) begin
            case (width_i)
                WIDTH_FULL: acc_q <= in_data_i;
                WIDTH_HALF: begin
                    if (slot[0])
                        acc_q[WORD_W-1:HALF_W] <= in_data_i[HALF_W-1:0];
                    else
                        acc_q[HALF_W-1:0] <= in_data_i[HALF_W-1:0];
                end
                default: acc_q[int'(slot)*LANE_W +: LANE_W] <= in_data_i[LANE_W-1:0];
            endcase
        end
    end

    // Count pieces; mark the word complete after the final one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            cnt_q  <= '0;
        end else if (take) begin
            if (cnt_q == last_piece(width_i)) begin
                full_q <= 1'b1;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end else if (full_q && out_ready_i) begin
            full_q <= 1'b0;
        end
    end

endmodule

// File: rtl/bus_width_matcher.sv
// Top: bus-width matcher between a fixed wide datapath and a narrow port of
// full, half or quarter width. Holds the configuration latch, one outbound
// splitter and one inbound packer. Both directions share the configuration
// and are otherwise independent. Single clock, synchronous active-low reset.
module bus_width_matcher
    import bwm_pkg::*;
#(
    parameter int unsigned WORD_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_match,
    input  logic              size_sel,
    input  logic              big_endian,
    input  logic              wide_in_valid,
    output logic              wide_in_ready,
    input  logic [WORD_W-1:0] wide_in_data,
    output logic              nar_out_valid,
    input  logic              nar_out_ready,
    output logic [WORD_W-1:0] nar_out_data,
    input  logic              nar_in_valid,
    output logic              nar_in_ready,
    input  logic [WORD_W-1:0] nar_in_data,
    output logic              wide_out_valid,
    input  logic              wide_out_ready,
    output logic [WORD_W-1:0] wide_out_data
);

    width_e width_q;
    logic   big_q;

    bwm_cfg u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_match_i  (bus_match),
        .size_sel_i   (size_sel),
        .big_endian_i (big_endian),
        .width_o      (width_q),
        .big_o        (big_q)
    );

    bwm_splitter #(.WORD_W(WORD_W)) u_split (
        .clk         (clk),
        .rst_n       (rst_n),
        .width_i     (width_q),
        .big_i       (big_q),
        .in_valid_i  (wide_in_valid),
        .in_ready_o  (wide_in_ready),
        .in_data_i   (wide_in_data),
        .out_valid_o (nar_out_valid),
        .out_ready_i (nar_out_ready),
        .out_data_o  (nar_out_data)
    );

    bwm_packer #(.WORD_W(WORD_W)) u_pack (
        .clk         (clk),
        .rst_n       (rst_n),
        .width_i     (width_q),
        .big_i       (big_q),
        .in_valid_i  (nar_in_valid),
        .in_ready_o  (nar_in_ready),
        .in_data_i   (nar_in_data),
        .out_valid_o (wide_out_valid),
        .out_ready_i (wide_out_ready),
        .out_data_o  (wide_out_data)
    );

endmodule

// File: rtl/bwm_checker.sv
// Checker: temporal properties of the bus-width matcher, bound to the top.
module bwm_checker
    import bwm_pkg::*;
#(
    parameter int unsigned WORD_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        width_q,
    input logic              big_q,
    input logic              wide_in_valid,
    input logic              wide_in_ready,
    input logic              nar_out_valid,
    input logic              nar_out_ready,
    input logic [WORD_W-1:0] nar_out_data,
    input logic              nar_in_ready,
    input logic              wide_out_valid,
    input logic              wide_out_ready,
    input logic [WORD_W-1:0] wide_out_data
);

    localparam int unsigned LANE_W = WORD_W / LANE_CNT;
    localparam int unsigned HALF_W = WORD_W / 2;

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (wide_in_ready && nar_in_ready && !nar_out_valid && !wide_out_valid));

    assert_full_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (nar_out_valid && nar_out_ready && width_q == WIDTH_FULL) |=> !nar_out_valid);

    assert_accept_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wide_in_valid && wide_in_ready) |=> (nar_out_valid && !wide_in_ready));

    assert_word_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wide_out_valid && !wide_out_ready) |=> (wide_out_valid && $stable(wide_out_data)));

    assert_full_stalls_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wide_out_valid |-> !nar_in_ready);

    assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($stable(width_q) && $stable(big_q)));

    assert_quarter_upper_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (nar_out_valid && width_q == WIDTH_QUARTER) |-> (nar_out_data[WORD_W-1:LANE_W] == '0));

    assert_half_upper_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (nar_out_valid && width_q == WIDTH_HALF) |-> (nar_out_data[WORD_W-1:HALF_W] == '0));

    assert_piece_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (nar_out_valid && !nar_out_ready) |=> (nar_out_valid && $stable(nar_out_data)));

endmodule

bind bus_width_matcher bwm_checker #(.WORD_W(WORD_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .width_q        (width_q),
    .big_q          (big_q),
    .wide_in_valid  (wide_in_valid),
    .wide_in_ready  (wide_in_ready),
    .nar_out_valid  (nar_out_valid),
    .nar_out_ready  (nar_out_ready),
    .nar_out_data   (nar_out_data),
    .nar_in_ready   (nar_in_ready),
    .wide_out_valid (wide_out_valid),
    .wide_out_ready (wide_out_ready),
    .wide_out_data  (wide_out_data)
);

// File: tb/bus_width_matcher_tb.sv
module bus_width_matcher_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_match = 1'b0, size_sel = 1'b0, big_endian = 1'b0;
    logic        wide_in_valid = 1'b0, nar_out_ready = 1'b0;
    logic        nar_in_valid = 1'b0, wide_out_ready = 1'b0;
    logic [35:0] wide_in_data = '0, nar_in_data = '0;
    logic        wide_in_ready, nar_out_valid, nar_in_ready, wide_out_valid;
    logic [35:0] nar_out_data, wide_out_data;

    int total = 0;
    int bad   = 0;
    logic [35:0] got [4];

    always #5 clk = ~clk;

    bus_width_matcher u_dut (
        .clk(clk), .rst_n(rst_n), .bus_match(bus_match), .size_sel(size_sel),
        .big_endian(big_endian), .wide_in_valid(wide_in_valid),
        .wide_in_ready(wide_in_ready), .wide_in_data(wide_in_data),
        .nar_out_valid(nar_out_valid), .nar_out_ready(nar_out_ready),
        .nar_out_data(nar_out_data), .nar_in_valid(nar_in_valid),
        .nar_in_ready(nar_in_ready), .nar_in_data(nar_in_data),
        .wide_out_valid(wide_out_valid), .wide_out_ready(wide_out_ready),
        .wide_out_data(wide_out_data)
    );

    typedef struct packed {
        logic        bm;
        logic        sz;
        logic        big;
        logic [2:0]  n;
        logic [35:0] word;
        logic [35:0] p0;
        logic [35:0] p1;
        logic [35:0] p2;
        logic [35:0] p3;
    } vec_t;

    localparam logic [8:0]  B3 = 9'h1A5, B2 = 9'h0C3, B1 = 9'h15A, B0 = 9'h03C;
    localparam logic [35:0] WD = {B3, B2, B1, B0};
    localparam logic [35:0] Z  = 36'h0;

    localparam vec_t TBL [6] = '{
        '{1'b0, 1'b0, 1'b0, 3'd1, WD, WD, Z, Z, Z},
        '{1'b0, 1'b0, 1'b1, 3'd1, 36'h9_8765_4321, 36'h9_8765_4321, Z, Z, Z},
        '{1'b1, 1'b0, 1'b0, 3'd2, WD, {18'h0, B1, B0}, {18'h0, B3, B2}, Z, Z},
        '{1'b1, 1'b0, 1'b1, 3'd2, WD, {18'h0, B3, B2}, {18'h0, B1, B0}, Z, Z},
        '{1'b1, 1'b1, 1'b0, 3'd4, WD, {27'h0, B0}, {27'h0, B1}, {27'h0, B2}, {27'h0, B3}},
        '{1'b1, 1'b1, 1'b1, 3'd4, WD, {27'h0, B3}, {27'h0, B2}, {27'h0, B1}, {27'h0, B0}}
    };

    function automatic logic [35:0] pick(input vec_t v, input int k);
        case (k)
            0: return v.p0;
            1: return v.p1;
            2: return v.p2;
            default: return v.p3;
        endcase
    endfunction

    function automatic logic [35:0] lane_mask(input int n);
        if (n == 1) return {36{1'b1}};
        if (n == 2) return 36'h0_0003_FFFF;
        return 36'h0_0000_01FF;
    endfunction

    task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic bm, input logic sz, input logic big);
        @(negedge clk);
        bus_match = bm; size_sel = sz; big_endian = big; rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic push_wide(input logic [35:0] w);
        wide_in_valid = 1'b1; wide_in_data = w;
        while (!wide_in_ready) @(negedge clk);
        @(negedge clk);
        wide_in_valid = 1'b0;
    endtask

    task automatic pull_pieces(input int n);
        for (int k = 0; k < n; k++) begin
            chk("R5 ready low while splitting", {35'h0, wide_in_ready}, 36'h0);
            while (!nar_out_valid) @(negedge clk);
            got[k] = nar_out_data;
            nar_out_ready = 1'b1;
            @(negedge clk);
            nar_out_ready = 1'b0;
        end
        chk("R5 ready back after last piece", {35'h0, wide_in_ready}, 36'h1);
        chk("R2 no extra piece", {35'h0, nar_out_valid}, 36'h0);
    endtask

    task automatic push_narrow(input logic [35:0] p);
        nar_in_valid = 1'b1; nar_in_data = p;
        while (!nar_in_ready) @(negedge clk);
        @(negedge clk);
        nar_in_valid = 1'b0;
    endtask

    task automatic drain_wide();
        wide_out_ready = 1'b1;
        @(negedge clk);
        wide_out_ready = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        // Table walk: split then reassemble each configuration.
        for (int i = 0; i < 6; i++) begin
            vec_t v;
            int   n;
            string tw, tn;
            v  = TBL[i];
            n  = int'(v.n);
            tw = (n == 1) ? "R2" : (n == 2) ? "R3" : "R4";
            tn = (n == 1) ? "R6" : (n == 2) ? "R7" : "R8";
            do_reset(v.bm, v.sz, v.big);
            if (i == 0) begin
                chk("R1 wide_in_ready", {35'h0, wide_in_ready}, 36'h1);
                chk("R1 nar_in_ready", {35'h0, nar_in_ready}, 36'h1);
                chk("R1 nar_out_valid", {35'h0, nar_out_valid}, 36'h0);
                chk("R1 wide_out_valid", {35'h0, wide_out_valid}, 36'h0);
            end
            push_wide(v.word);
            pull_pieces(n);
            for (int k = 0; k < n; k++)
                chk({tw, "/R12 piece order"}, got[k], pick(v, k));
            for (int k = 0; k < n; k++) begin
                chk("R9 no early word", {35'h0, wide_out_valid}, 36'h0);
                push_narrow(pick(v, k) | ~lane_mask(n));
            end
            chk("R9 word valid", {35'h0, wide_out_valid}, 36'h1);
            chk("R9 narrow stalled", {35'h0, nar_in_ready}, 36'h0);
            chk({tn, "/R12 assembled"}, wide_out_data, v.word);
            @(negedge clk);
            chk("R9 word held", wide_out_data, v.word);
            drain_wide();
            chk("R9 word released", {35'h0, wide_out_valid}, 36'h0);
        end

        // R10: pins moved after reset have no effect.
        do_reset(1'b1, 1'b1, 1'b0);
        bus_match = 1'b0; big_endian = 1'b1;
        push_wide(WD);
        pull_pieces(4);
        chk("R10 lane0", got[0], {27'h0, B0});
        chk("R10 lane1", got[1], {27'h0, B1});
        chk("R10 lane2", got[2], {27'h0, B2});
        chk("R10 lane3", got[3], {27'h0, B3});

        // R13: piece held under back-pressure.
        do_reset(1'b1, 1'b0, 1'b1);
        push_wide(WD);
        for (int k = 0; k < 3; k++) begin
            chk("R13 valid held", {35'h0, nar_out_valid}, 36'h1);
            chk("R13 data held", nar_out_data, {18'h0, B3, B2});
            @(negedge clk);
        end
        pull_pieces(2);
        chk("R13 second piece", got[1], {18'h0, B1, B0});

        // R11: reset discards a partial word.
        do_reset(1'b1, 1'b1, 1'b0);
        push_narrow(36'h111);
        push_narrow(36'h0AA);
        do_reset(1'b1, 1'b1, 1'b0);
        chk("R11 no word after reset", {35'h0, wide_out_valid}, 36'h0);
        chk("R11 ready after reset", {35'h0, nar_in_ready}, 36'h1);
        push_narrow({27'h0, B0});
        push_narrow({27'h0, B1});
        chk("R11 still collecting", {35'h0, wide_out_valid}, 36'h0);
        push_narrow({27'h0, B2});
        push_narrow({27'h0, B3});
        chk("R11 fresh word", wide_out_data, WD);
        drain_wide();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule